// File: doc/BRIEF.md
# Flash Bus Front End

This block sits at the device pins of a parallel NOR-style flash and turns the asynchronous, active-low control strobes into a clean, clocked view of the bus. Every system clock it classifies the bus into one of five states: power-down, standby, output disable, read or write. Strict priority applies: power-down overrides everything, standby overrides the enables, and output disable overrides read. Only a read drives the data pins. The data-pin enable and the data word are both registered.

For writes the block keeps a shadow of the address and data word, and freezes it when either write enable or chip enable rises, whichever rises first. When the write ends it hands the frozen pair to the downstream command logic with a single-cycle strobe. Chip enable and write enable pass through a filter, so a pulse shorter than a parameterised number of clock samples cannot start or end any operation. During asynchronous reads an idle timer raises an automatic low-power flag after the bus has been quiet for a set number of cycles. The block also holds the read-path selection, which returns to array read on reset or power-down, and reports a protocol error when output enable is low during a write.

Top module: `flash_bus_front`

## Requirements
- R1: With `rp_n` low, `mode_o` is 0 (power-down) and `dq_oe_o` is low, whatever `ce_n`, `oe_n` and `we_n` are.
- R2: With `rp_n` high and `ce_n` high, `mode_o` is 1 (standby) and `dq_oe_o` is low, whatever `oe_n` and `we_n` are.
- R3: With `rp_n` high, `ce_n` low, `we_n` high and `oe_n` high, `mode_o` is 2 (output disable) and `dq_oe_o` is low.
- R4: With `rp_n` high, `ce_n` low, `we_n` high and `oe_n` low, `mode_o` is 3 (read), `dq_oe_o` is high and `dq_o` follows `rd_data_i` with a one-cycle register delay.
- R5: A write (`ce_n` and `we_n` both low, `mode_o` 4) ends with exactly one single-cycle `wr_strobe_o`. `wr_addr_o` and `wr_data_o` then hold the `addr_i` and `dq_i` values present when the first of `we_n` and `ce_n` rose. Changes after that first rise are not captured.
- R6: A pulse on `ce_n` or `we_n` lasting fewer than `GLITCH_CYC` clock cycles changes neither `mode_o` nor `wr_strobe_o`. A pulse held for at least `GLITCH_CYC` cycles is acted on.
- R7: `rd_mode_o` is 0 (array read) after `rst` and at all times while in power-down. Outside power-down, `rd_mode_ld_i` loads `rd_mode_i` into it.
- R8: In read with `sync_mode_i` low, once the control pins and address have been unchanged for `IDLE_CYC` cycles, `alp_o` goes high. Read data keeps being driven while it is high.
- R9: Any change on a control pin or the address clears `alp_o` and restarts the idle count. `alp_o` is never high outside read or while `sync_mode_i` is high.
- R10: `stby_lp_o` is high exactly when `mode_o` is 1 (standby) and `pe_busy_i` is low.
- R11: `proto_err_o` is high while a write is in progress (`mode_o` 4) with `oe_n` low. The data pins stay undriven during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rp_n | input | 1 | Reset/power-down pin, active low |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| addr_i | input | ADDR_W | Address pins |
| dq_i | input | DATA_W | Data pins, input side |
| rd_data_i | input | DATA_W | Read word from the array or register path |
| sync_mode_i | input | 1 | High when a synchronous read mode is selected |
| pe_busy_i | input | 1 | Program or erase operation running |
| rd_mode_ld_i | input | 1 | Load strobe for the read-path selection |
| rd_mode_i | input | 2 | Read-path selection to load |
| dq_o | output | DATA_W | Data pins, output side |
| dq_oe_o | output | 1 | Data pin output enable |
| wr_addr_o | output | ADDR_W | Captured write address |
| wr_data_o | output | DATA_W | Captured write data |
| wr_strobe_o | output | 1 | One-cycle pulse when a write completes |
| proto_err_o | output | 1 | Output enable low during a write |
| mode_o | output | 3 | Bus state code: 0 power-down, 1 standby, 2 output disable, 3 read, 4 write |
| rd_mode_o | output | 2 | Current read-path selection, 0 is array read |
| alp_o | output | 1 | Automatic low-power flag |
| stby_lp_o | output | 1 | Standby with reduced activity permitted |

## Verification
The bench ends writes in both orders and moves the address and data after the first rising edge. A design that latched on the later edge, or kept sampling until the write state was left, would report the second address instead of the first. Short pulses on both enables are applied in the middle of a read, and a longer pulse follows them. An over-eager filter would pulse the strobe or drop out of read; a too-strict filter would miss the legal write. The idle flag is checked in the read state, then after an address change, in synchronous mode and in output disable, which catches a timer that ignores its enable conditions or is not cleared by activity. The bench also loads a read selection and checks that power-down and reset both return it to array read.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic [2:0] {
    M_PDOWN   = 3'd0,
    M_STANDBY = 3'd1,
    M_OUTDIS  = 3'd2,
    M_READ    = 3'd3,
    M_WRITE   = 3'd4
  } bus_mode_e;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_SIGN   = 2'd1,
    RD_STATUS = 2'd2,
    RD_QUERY  = 2'd3
  } rd_path_e;
endpackage

// File: rtl/fbf_sync.sv
module fbf_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fbf_deglitch.sv
module fbf_deglitch #(
  parameter int GLITCH_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic s,
  output logic f
);
  localparam int CW = $clog2(GLITCH_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

  logic [CW-1:0] cnt;

  // the filtered level flips only after GLITCH_CYC consecutive disagreeing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      f   <= 1'b1;
      cnt <= '0;
    end else if (s == f) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      f   <= s;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fbf_idle.sv
module fbf_idle #(
  parameter int IDLE_CYC = 1024,
  parameter int W        = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] sig,
  output logic         alp
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYC - 1);

  logic [W-1:0]  prev;
  logic [CW-1:0] cnt;
  logic          moved;

  assign moved = (sig != prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      cnt  <= '0;
      alp  <= 1'b0;
    end else begin
      prev <= sig;
      if (!en || moved) begin
        cnt <= '0;
        alp <= 1'b0;
      end else if (cnt == LAST) begin
        alp <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import fbf_pkg::*;
#(
  parameter int ADDR_W      = 23,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 3,
  parameter int IDLE_CYC    = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rp_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              sync_mode_i,
  input  logic              pe_busy_i,
  input  logic              rd_mode_ld_i,
  input  logic [1:0]        rd_mode_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_strobe_o,
  output logic              proto_err_o,
  output logic [2:0]        mode_o,
  output logic [1:0]        rd_mode_o,
  output logic              alp_o,
  output logic              stby_lp_o
);
  localparam int CTRL_W = 4;
  localparam int BUS_W  = ADDR_W + DATA_W;
  localparam int MON_W  = CTRL_W + ADDR_W;
  localparam int N_FLT  = 2;

  // synchronised pins
  logic [CTRL_W-1:0] ctrl_s;
  logic [BUS_W-1:0]  bus_s;
  logic              rp_s, ce_s, oe_s, we_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  fbf_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTRL_W{1'b1}})) u_sync_ctrl (
    .clk(clk), .rst(rst), .d({rp_n, ce_n, oe_n, we_n}), .q(ctrl_s)
  );

  // address/data ride a pipeline of equal depth so they stay aligned with the strobes
  fbf_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst(rst), .d({addr_i, dq_i}), .q(bus_s)
  );

  assign {rp_s, ce_s, oe_s, we_s} = ctrl_s;
  assign {addr_s, data_s}         = bus_s;

  // glitch filters on the two enables
  logic [N_FLT-1:0] raw_en, filt_en;
  logic             ce_f, we_f;

  assign raw_en = {ce_s, we_s};

  for (genvar gi = 0; gi < N_FLT; gi++) begin : g_flt
    fbf_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_flt (
      .clk(clk), .rst(rst), .s(raw_en[gi]), .f(filt_en[gi])
    );
  end

  assign {ce_f, we_f} = filt_en;

  // bus state, fixed priority
  bus_mode_e mode_d, mode_q;

  always_comb begin
    if (!rp_s)      mode_d = M_PDOWN;
    else if (ce_f)  mode_d = M_STANDBY;
    else if (!we_f) mode_d = M_WRITE;
    else if (oe_s)  mode_d = M_OUTDIS;
    else            mode_d = M_READ;
  end

  // write shadow: follows the bus while both strobes are low, so it holds
  // the values seen at whichever strobe rose first
  logic              shadow_en;
  logic [ADDR_W-1:0] sh_addr;
  logic [DATA_W-1:0] sh_data;
  logic              wr_done;

  assign shadow_en = rp_s && !ce_s && !we_s;
  assign wr_done   = (mode_q == M_WRITE) && (mode_d != M_WRITE) && (mode_d != M_PDOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_addr <= '0;
      sh_data <= '0;
    end else if (shadow_en) begin
      sh_addr <= addr_s;
      sh_data <= data_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_strobe_o <= 1'b0;
    end else begin
      wr_strobe_o <= wr_done;
      if (wr_done) begin
        wr_addr_o <= sh_addr;
        wr_data_o <= sh_data;
      end
    end
  end

  // registered pin-side outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_STANDBY;
      dq_oe_o     <= 1'b0;
      dq_o        <= '0;
      proto_err_o <= 1'b0;
      stby_lp_o   <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      dq_oe_o     <= (mode_d == M_READ);
      dq_o        <= (mode_d == M_READ) ? rd_data_i : '0;
      proto_err_o <= (mode_d == M_WRITE) && !oe_s;
      stby_lp_o   <= (mode_d == M_STANDBY) && !pe_busy_i;
    end
  end

  assign mode_o = mode_q;

  // read-path selection, back to array read on reset or power-down
  rd_path_e rd_path_q;

  always_ff @(posedge clk) begin
    if (rst || (mode_d == M_PDOWN)) rd_path_q <= RD_ARRAY;
    else if (rd_mode_ld_i)          rd_path_q <= rd_path_e'(rd_mode_i);
  end

  assign rd_mode_o = rd_path_q;

  // idle timer for automatic low power
  logic idle_en;
  assign idle_en = (mode_d == M_READ) && !sync_mode_i;

  fbf_idle #(.IDLE_CYC(IDLE_CYC), .W(MON_W)) u_idle (
    .clk(clk), .rst(rst), .en(idle_en), .sig({ctrl_s, addr_s}), .alp(alp_o)
  );
endmodule

// File: rtl/fbf_checker.sv
module fbf_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode_o,
  input logic       dq_oe_o,
  input logic       wr_strobe_o,
  input logic       proto_err_o,
  input logic [1:0] rd_mode_o,
  input logic       alp_o,
  input logic       stby_lp_o
);
  AST_PDOWN_HIZ: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd0) |-> !dq_oe_o); // R1
  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd1) |-> !dq_oe_o); // R2
  AST_OUTDIS_HIZ: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd2) |-> !dq_oe_o); // R3
  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> (mode_o == 3'd3)); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_o |=> !wr_strobe_o); // R5
  AST_RDPATH_PDOWN: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd0) |-> (rd_mode_o == 2'd0)); // R7
  AST_ALP_IN_READ: assert property (@(posedge clk) disable iff (rst)
    alp_o |-> (mode_o == 3'd3)); // R9
  AST_STBY_LP_MODE: assert property (@(posedge clk) disable iff (rst)
    stby_lp_o |-> (mode_o == 3'd1)); // R10
  AST_PERR_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |-> (mode_o == 3'd4) && !dq_oe_o); // R11
endmodule

bind flash_bus_front fbf_checker u_fbf_checker (
  .clk(clk), .rst(rst), .mode_o(mode_o), .dq_oe_o(dq_oe_o),
  .wr_strobe_o(wr_strobe_o), .proto_err_o(proto_err_o), .rd_mode_o(rd_mode_o),
  .alp_o(alp_o), .stby_lp_o(stby_lp_o)
);

// File: tb/test_flash_bus_front.sv
`timescale 1ns/1ps
module test_flash_bus_front;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam int GL = 3;
  localparam int IDLE = 16;
  localparam int SETTLE = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rp_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] dq_i = '0, rd_data_i = '0;
  logic sync_mode_i = 1'b0, pe_busy_i = 1'b0, rd_mode_ld_i = 1'b0;
  logic [1:0] rd_mode_i = 2'd0;
  logic [DW-1:0] dq_o;
  logic dq_oe_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;
  logic wr_strobe_o, proto_err_o, alp_o, stby_lp_o;
  logic [2:0] mode_o;
  logic [1:0] rd_mode_o;

  int checks = 0;
  int errors = 0;
  int strobe_cnt = 0;
  int off_read_cnt = 0;
  bit watch_read = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_bus_front #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .GLITCH_CYC(GL), .IDLE_CYC(IDLE))
  i_flash_bus_front (
    .clk(clk), .rst(rst), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr_i(addr_i), .dq_i(dq_i), .rd_data_i(rd_data_i), .sync_mode_i(sync_mode_i),
    .pe_busy_i(pe_busy_i), .rd_mode_ld_i(rd_mode_ld_i), .rd_mode_i(rd_mode_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_strobe_o(wr_strobe_o), .proto_err_o(proto_err_o), .mode_o(mode_o),
    .rd_mode_o(rd_mode_o), .alp_o(alp_o), .stby_lp_o(stby_lp_o)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (wr_strobe_o) strobe_cnt++;
      if (watch_read && mode_o != 3'd3) off_read_cnt++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    chk("R2 reset mode", mode_o, 3'd1);
    chk("R2 reset oe", dq_oe_o, 1'b0);
    chk("R7 reset path", rd_mode_o, 2'd0);
    chk("R9 reset alp", alp_o, 1'b0);
    chk("R5 reset strobe", wr_strobe_o, 1'b0);
  endtask

  task automatic t_pdown();
    rp_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    wait_cyc(SETTLE);
    chk("R1 pdown mode", mode_o, 3'd0);
    chk("R1 pdown hiz", dq_oe_o, 1'b0);
    rd_mode_ld_i = 1'b1; rd_mode_i = 2'd2;
    wait_cyc(1);
    rd_mode_ld_i = 1'b0;
    wait_cyc(1);
    chk("R7 load ignored in pdown", rd_mode_o, 2'd0);
    rp_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    wait_cyc(SETTLE);
  endtask

  task automatic t_standby();
    oe_n = 1'b0; pe_busy_i = 1'b0;
    wait_cyc(SETTLE);
    chk("R2 standby mode", mode_o, 3'd1);
    chk("R2 standby hiz", dq_oe_o, 1'b0);
    chk("R10 standby lp idle", stby_lp_o, 1'b1);
    pe_busy_i = 1'b1;
    wait_cyc(3);
    chk("R10 standby lp busy", stby_lp_o, 1'b0);
    pe_busy_i = 1'b0;
    oe_n = 1'b1;
    wait_cyc(SETTLE);
  endtask

  task automatic t_outdis_read();
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    wait_cyc(SETTLE);
    chk("R3 outdis mode", mode_o, 3'd2);
    chk("R3 outdis hiz", dq_oe_o, 1'b0);
    rd_data_i = 16'hA5C3; oe_n = 1'b0;
    wait_cyc(SETTLE);
    chk("R4 read mode", mode_o, 3'd3);
    chk("R4 read drive", dq_oe_o, 1'b1);
    chk("R4 read data", dq_o, 16'hA5C3);
    rd_data_i = 16'h1234;
    wait_cyc(2);
    chk("R4 read data follows", dq_o, 16'h1234);
    oe_n = 1'b1; ce_n = 1'b1;
    wait_cyc(SETTLE);
  endtask

  task automatic t_write_we_first();
    strobe_cnt = 0;
    ce_n = 1'b0; addr_i = 23'h0ABCDE; dq_i = 16'hBEEF; we_n = 1'b0;
    wait_cyc(SETTLE);
    chk("R5 write mode", mode_o, 3'd4);
    we_n = 1'b1;
    wait_cyc(1);
    addr_i = 23'h012345; dq_i = 16'h0F0F;
    wait_cyc(3);
    ce_n = 1'b1;
    wait_cyc(SETTLE);
    chk("R5 we-first strobe count", strobe_cnt, 1);
    chk("R5 we-first addr", wr_addr_o, 23'h0ABCDE);
    chk("R5 we-first data", wr_data_o, 16'hBEEF);
  endtask

  task automatic t_write_ce_first();
    strobe_cnt = 0;
    addr_i = 23'h7F00AA; dq_i = 16'h5A5A; we_n = 1'b0; ce_n = 1'b0;
    wait_cyc(SETTLE);
    ce_n = 1'b1;
    wait_cyc(1);
    addr_i = 23'h000111; dq_i = 16'h2222;
    wait_cyc(3);
    we_n = 1'b1;
    wait_cyc(SETTLE);
    chk("R5 ce-first strobe count", strobe_cnt, 1);
    chk("R5 ce-first addr", wr_addr_o, 23'h7F00AA);
    chk("R5 ce-first data", wr_data_o, 16'h5A5A);
  endtask

  task automatic t_glitch();
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    wait_cyc(SETTLE);
    strobe_cnt = 0; off_read_cnt = 0; watch_read = 1'b1;
    we_n = 1'b0; wait_cyc(GL - 1); we_n = 1'b1;
    wait_cyc(SETTLE);
    ce_n = 1'b1; wait_cyc(GL - 1); ce_n = 1'b0;
    wait_cyc(SETTLE);
    watch_read = 1'b0;
    chk("R6 short pulses keep read", off_read_cnt, 0);
    chk("R6 short pulse no strobe", strobe_cnt, 0);
    oe_n = 1'b1;
    wait_cyc(SETTLE);
    strobe_cnt = 0;
    we_n = 1'b0; wait_cyc(GL + 1); we_n = 1'b1;
    wait_cyc(SETTLE);
    chk("R6 long pulse accepted", strobe_cnt, 1);
    ce_n = 1'b1;
    wait_cyc(SETTLE);
  endtask

  task automatic t_idle();
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; sync_mode_i = 1'b0;
    rd_data_i = 16'h6E6E; addr_i = 23'h000040;
    wait_cyc(IDLE + SETTLE + 5);
    chk("R8 alp after idle", alp_o, 1'b1);
    chk("R8 data still driven", dq_oe_o, 1'b1);
    chk("R8 data value", dq_o, 16'h6E6E);
    addr_i = 23'h000041;
    wait_cyc(5);
    chk("R9 alp cleared by address", alp_o, 1'b0);
    sync_mode_i = 1'b1;
    wait_cyc(IDLE + SETTLE + 10);
    chk("R9 no alp in sync mode", alp_o, 1'b0);
    sync_mode_i = 1'b0; oe_n = 1'b1;
    wait_cyc(IDLE + SETTLE + 10);
    chk("R9 no alp in outdis", alp_o, 1'b0);
    ce_n = 1'b1;
    wait_cyc(SETTLE);
  endtask

  task automatic t_proto();
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    wait_cyc(SETTLE);
    chk("R11 proto err", proto_err_o, 1'b1);
    chk("R11 bus undriven", dq_oe_o, 1'b0);
    oe_n = 1'b1;
    wait_cyc(SETTLE);
    chk("R11 proto err clears", proto_err_o, 1'b0);
    we_n = 1'b1; ce_n = 1'b1;
    wait_cyc(SETTLE);
  endtask

  task automatic t_rdpath();
    rd_mode_ld_i = 1'b1; rd_mode_i = 2'd3;
    wait_cyc(1);
    rd_mode_ld_i = 1'b0;
    wait_cyc(1);
    chk("R7 path load", rd_mode_o, 2'd3);
    rp_n = 1'b0;
    wait_cyc(SETTLE);
    chk("R7 path back to array on pdown", rd_mode_o, 2'd0);
    rp_n = 1'b1;
    wait_cyc(SETTLE);
    rd_mode_ld_i = 1'b1; rd_mode_i = 2'd2;
    wait_cyc(1);
    rd_mode_ld_i = 1'b0;
    rst = 1'b1;
    wait_cyc(2);
    rst = 1'b0;
    wait_cyc(1);
    chk("R7 path back to array on reset", rd_mode_o, 2'd0);
  endtask

  initial begin
    t_reset();
    t_pdown();
    t_standby();
    t_outdis_read();
    t_write_we_first();
    t_write_ce_first();
    t_glitch();
    t_idle();
    t_proto();
    t_rdpath();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule